// File: doc/BRIEF.md
# Test-Bus Capture DMA Engine

This block records a stream of 32-bit words from an on-chip test bus into system memory. Accepted words go into a small capture FIFO. A write sequencer then drains the FIFO through a single-master bus port. Each transfer is one word: a one-cycle address phase, then a data phase that waits for a ready signal. Software controls the engine through a small register port. That port holds a control word, a memory start address and a word count, plus a status word and read-only views of the live address and the remaining count.

The engine has two modes. In one-shot mode it takes a programmed number of words and then drops its own enable. In circular mode it keeps filling a window of memory. The window starts at the programmed address and spans the programmed count. When the end of the window is written, the address returns to the start. This repeats until software clears the enable. A sticky flag records any word that was lost because the FIFO was full. A forced-request option keeps the bus request high for the whole run, so the engine does not re-arbitrate between words.

Top module: `tbcap_dma`

## Requirements
- R1: Register map, with byte offsets decoded from address bits [4:2]:
  - Control at 0x0, with bit 0 = enable, bit 1 = circular, bit 2 = forced request; it reads back as written.
  - Start address at 0x4; it reads as written with bits [1:0] forced to 0.
  - Count at 0x8; it keeps the low 17 bits and holds the number of words minus one.
  - Status at 0xC, with bit 0 = active and bit 1 = overflow.
  - Live address at 0x10 and remaining count at 0x14.
  - After reset, every register reads 0.
- R2: Writing 1 to the enable while it is 0 loads the live address from the start address and the remaining count from the count register.
- R3: In one-shot mode, exactly count+1 accepted words are captured. The enable then reads 0 and later words are ignored.
- R4: Words are written in capture order, at consecutive word addresses from the start address. The remaining count drops by one per write. After the last write of a one-shot run it holds 0, and the live address points one word past the last write.
- R5: In circular mode, the write that follows the one at start+4*count goes to the start address again, and the remaining count reloads. The enable stays 1 until software writes it to 0.
- R6: Status active reads 1 in the cycle after the enable is written to 1. It returns to 0 only after capture has stopped, the FIFO is empty and no write is in progress.
- R7: The FIFO holds 8 words. A word offered while the FIFO is full is dropped and sets status bit 1, and capture continues. The flag stays set until a write to the status register with bit 1 = 1. Writing 0 to bit 1 leaves the flag set.
- R8: A bus write starts with an address phase of exactly one cycle, one cycle after a grant seen while the FIFO is non-empty. The data phase follows. While ready is low, the data phase holds the address and data stable.
- R9: With forced request off, the request is high exactly while the FIFO is non-empty or a write is under way. It drops for one cycle after each completed write.
- R10: With forced request on, the request stays high for as long as the engine is active, including when the FIFO is empty and in the cycle after each write.
- R11: Writes to the start address and count registers are ignored while the engine is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| cap_valid | input | 1 | Test-bus word present |
| cap_data | input | 32 | Test-bus word |
| m_req | output | 1 | Bus request |
| m_grant | input | 1 | Bus grant |
| m_avalid | output | 1 | Address phase active |
| m_addr | output | 32 | Byte address of the write |
| m_dvalid | output | 1 | Data phase active |
| m_wdata | output | 32 | Write data |
| m_ready | input | 1 | Data phase completes when high |

## Verification
Several internal faults would show up in the memory-side log within a few cycles:
- A wrong FIFO pointer would put data in the wrong order.
- A wrong live-address or remaining-count counter would put writes at the wrong place, or would miss or misplace the wrap in circular mode.
- A wrong capture counter would change the number of logged writes, or leave the enable set after a one-shot run.

The sequencer state shows at the request pin in the cycle after each completed write, and in the data-phase hold while ready is low. A wrong overflow flag or a wrong active flag shows on the next status read.

// File: rtl/tbcap_pkg.sv
package tbcap_pkg;

    localparam int REG_W   = 32;
    localparam int WADDR_W = REG_W - 2;

    // Register index = byte offset / 4
    localparam logic [2:0] IDX_CTRL   = 3'd0;
    localparam logic [2:0] IDX_START  = 3'd1;
    localparam logic [2:0] IDX_COUNT  = 3'd2;
    localparam logic [2:0] IDX_STATUS = 3'd3;
    localparam logic [2:0] IDX_LIVEA  = 3'd4;
    localparam logic [2:0] IDX_REMAIN = 3'd5;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ADDR,
        SEQ_DATA,
        SEQ_GAP
    } seq_state_e;

    typedef struct packed {
        logic force_req;
        logic circ;
        logic en;
    } ctrl_t;

    function automatic logic [REG_W-1:0] word_to_byte(input logic [WADDR_W-1:0] w);
        return {w, 2'b00};
    endfunction

endpackage

// File: rtl/tbcap_fifo.sv
module tbcap_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;

    assign empty = (fill == '0);
    assign full  = (fill == CW'(DEPTH));
    assign rdata = store[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/tbcap_regs.sv
module tbcap_regs
    import tbcap_pkg::*;
#(
    parameter int LEN_W  = 17,
    parameter int RADDR_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               accept,
    input  logic               ovf_event,
    input  logic               active,
    input  logic [WADDR_W-1:0] live_w,
    input  logic [LEN_W-1:0]   remain,
    output ctrl_t              ctrl,
    output logic [WADDR_W-1:0] start_w,
    output logic [LEN_W-1:0]   count_q,
    output logic               start_pulse,
    output logic               ovf_q
);
    logic [2:0]       idx;
    logic             wr_ctrl, wr_start, wr_count, wr_status;
    logic [LEN_W-1:0] cap_cnt;
    logic             last_take;

    assign idx       = reg_addr[4:2];
    assign wr_ctrl   = reg_we && (idx == IDX_CTRL);
    assign wr_start  = reg_we && (idx == IDX_START)  && !active;
    assign wr_count  = reg_we && (idx == IDX_COUNT)  && !active;
    assign wr_status = reg_we && (idx == IDX_STATUS);

    assign start_pulse = wr_ctrl && reg_wdata[0] && !ctrl.en;
    assign last_take   = accept && ctrl.en && !ctrl.circ && (cap_cnt == count_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_t'(reg_wdata[2:0]);
        end else if (last_take) begin
            ctrl.en <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_cnt <= '0;
        end else if (start_pulse) begin
            cap_cnt <= '0;
        end else if (accept) begin
            cap_cnt <= cap_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_w <= '0;
            count_q <= '0;
        end else begin
            if (wr_start) start_w <= reg_wdata[REG_W-1:2];
            if (wr_count) count_q <= reg_wdata[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (ovf_event) begin
            ovf_q <= 1'b1;
        end else if (wr_status && reg_wdata[1]) begin
            ovf_q <= 1'b0;
        end
    end

    always_comb begin
        case (idx)
            IDX_CTRL:   reg_rdata = {{(REG_W-3){1'b0}}, ctrl.force_req, ctrl.circ, ctrl.en};
            IDX_START:  reg_rdata = word_to_byte(start_w);
            IDX_COUNT:  reg_rdata = {{(REG_W-LEN_W){1'b0}}, count_q};
            IDX_STATUS: reg_rdata = {{(REG_W-2){1'b0}}, ovf_q, active};
            IDX_LIVEA:  reg_rdata = word_to_byte(live_w);
            IDX_REMAIN: reg_rdata = {{(REG_W-LEN_W){1'b0}}, remain};
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tbcap_master.sv
module tbcap_master
    import tbcap_pkg::*;
#(
    parameter int LEN_W  = 17,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               force_req,
    input  logic               circ,
    input  logic               active,
    input  logic               start_pulse,
    input  logic [WADDR_W-1:0] start_w,
    input  logic [LEN_W-1:0]   count_q,
    input  logic               fifo_empty,
    input  logic [DATA_W-1:0]  fifo_data,
    output logic               pop,
    input  logic               m_grant,
    input  logic               m_ready,
    output logic               m_req,
    output logic               m_avalid,
    output logic [REG_W-1:0]   m_addr,
    output logic               m_dvalid,
    output logic [DATA_W-1:0]  m_wdata,
    output logic [WADDR_W-1:0] live_w,
    output logic [LEN_W-1:0]   remain,
    output logic               busy
);
    seq_state_e state, state_nx;

    assign m_avalid = (state == SEQ_ADDR);
    assign m_dvalid = (state == SEQ_DATA);
    assign m_addr   = word_to_byte(live_w);
    assign m_wdata  = fifo_data;
    assign pop      = m_dvalid && m_ready;
    assign busy     = (state != SEQ_IDLE);

    always_comb begin
        case (state)
            SEQ_IDLE: m_req = force_req ? active : !fifo_empty;
            SEQ_GAP:  m_req = force_req && active;
            default:  m_req = 1'b1;
        endcase
    end

    always_comb begin
        state_nx = state;
        case (state)
            SEQ_IDLE: if (m_grant && !fifo_empty) state_nx = SEQ_ADDR;
            SEQ_ADDR: state_nx = SEQ_DATA;
            SEQ_DATA: if (m_ready) state_nx = SEQ_GAP;
            SEQ_GAP:  state_nx = SEQ_IDLE;
            default:  state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_w <= '0;
            remain <= '0;
        end else if (start_pulse) begin
            live_w <= start_w;
            remain <= count_q;
        end else if (pop) begin
            if (remain != '0) begin
                live_w <= live_w + 1'b1;
                remain <= remain - 1'b1;
            end else if (circ) begin
                live_w <= start_w;
                remain <= count_q;
            end else begin
                live_w <= live_w + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tbcap_dma.sv
module tbcap_dma
    import tbcap_pkg::*;
#(
    parameter int LEN_W      = 17,
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cap_valid,
    input  logic [31:0] cap_data,
    output logic        m_req,
    input  logic        m_grant,
    output logic        m_avalid,
    output logic [31:0] m_addr,
    output logic        m_dvalid,
    output logic [31:0] m_wdata,
    input  logic        m_ready
);
    ctrl_t              ctrl;
    logic [WADDR_W-1:0] start_w, live_w;
    logic [LEN_W-1:0]   count_q, remain;
    logic               start_pulse, ovf_q;
    logic               fifo_empty, fifo_full, pop, busy;
    logic [REG_W-1:0]   fifo_data;
    logic               accept, ovf_event, active;

    assign accept    = cap_valid && ctrl.en && !fifo_full;
    assign ovf_event = cap_valid && ctrl.en && fifo_full;
    assign active    = ctrl.en || !fifo_empty || busy;

    tbcap_regs #(.LEN_W(LEN_W), .RADDR_W(5)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .accept(accept), .ovf_event(ovf_event), .active(active),
        .live_w(live_w), .remain(remain),
        .ctrl(ctrl), .start_w(start_w), .count_q(count_q),
        .start_pulse(start_pulse), .ovf_q(ovf_q)
    );

    tbcap_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(accept), .wdata(cap_data),
        .pop(pop), .rdata(fifo_data),
        .empty(fifo_empty), .full(fifo_full)
    );

    tbcap_master #(.LEN_W(LEN_W), .DATA_W(REG_W)) u_master (
        .clk(clk), .rst(rst),
        .force_req(ctrl.force_req), .circ(ctrl.circ), .active(active),
        .start_pulse(start_pulse), .start_w(start_w), .count_q(count_q),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .pop(pop),
        .m_grant(m_grant), .m_ready(m_ready), .m_req(m_req),
        .m_avalid(m_avalid), .m_addr(m_addr), .m_dvalid(m_dvalid),
        .m_wdata(m_wdata), .live_w(live_w), .remain(remain), .busy(busy)
    );
endmodule

// File: rtl/tbcap_dma_chk.sv
module tbcap_dma_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [4:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        m_req,
    input logic        m_grant,
    input logic        m_avalid,
    input logic [31:0] m_addr,
    input logic        m_dvalid,
    input logic [31:0] m_wdata,
    input logic        m_ready,
    input logic        ovf_q,
    input logic        active,
    input logic        force_on,
    input logic        fifo_empty,
    input logic        pop
);
    assert_addr_then_data_R8: assert property (@(posedge clk) disable iff (rst)
        m_avalid |=> m_dvalid);

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
        m_dvalid && !m_ready |=> m_dvalid && $stable(m_wdata) && $stable(m_addr));

    assert_addr_after_grant_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(m_avalid) |-> $past(m_grant));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_q && !(reg_we && reg_addr[4:2] == 3'd3 && reg_wdata[1]) |=> ovf_q);

    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        m_dvalid && m_ready && !force_on |=> !m_req);

    assert_force_hold_R10: assert property (@(posedge clk) disable iff (rst)
        force_on && active |-> m_req);

    assert_write_active_R6: assert property (@(posedge clk) disable iff (rst)
        (m_avalid || m_dvalid) |-> active);

    assert_no_empty_pop_R4: assert property (@(posedge clk) disable iff (rst)
        pop |-> !fifo_empty);
endmodule

bind tbcap_dma tbcap_dma_chk u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .m_req(m_req), .m_grant(m_grant),
    .m_avalid(m_avalid), .m_addr(m_addr), .m_dvalid(m_dvalid),
    .m_wdata(m_wdata), .m_ready(m_ready), .ovf_q(ovf_q), .active(active),
    .force_on(ctrl.force_req), .fifo_empty(fifo_empty), .pop(pop)
);

// File: tb/tb_tbcap_dma.sv
module tb_tbcap_dma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_data = '0;
    logic        m_req, m_avalid, m_dvalid;
    logic [31:0] m_addr, m_wdata;
    logic        m_ready = 1'b0;
    logic        gnt_en = 1'b0;
    logic        m_grant;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 0;
    int          wait_cfg = 0;
    bit          force_mode = 0;

    logic [31:0] log_a[$];
    logic [31:0] log_d[$];

    always #2.5 clk = ~clk;
    assign m_grant = m_req && gnt_en;

    tbcap_dma dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cap_valid(cap_valid), .cap_data(cap_data),
        .m_req(m_req), .m_grant(m_grant), .m_avalid(m_avalid),
        .m_addr(m_addr), .m_dvalid(m_dvalid), .m_wdata(m_wdata),
        .m_ready(m_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Memory-side model, sampled and driven at the falling edge
    logic [31:0] lat_addr = '0;
    logic [31:0] prev_data = '0;
    bit          hold_prev = 0;
    bit          prev_av = 0;
    bit          gap_chk = 0;
    int          wcnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_av) check("R8 data phase after address", {31'b0, m_dvalid}, 32'd1);
            prev_av = m_avalid;
            if (m_avalid) lat_addr = m_addr;
            if (m_dvalid) begin
                if (hold_prev) check("R8 data held while not ready", m_wdata, prev_data);
                if (wcnt == 0) begin
                    m_ready = 1'b1;
                    log_a.push_back(lat_addr);
                    log_d.push_back(m_wdata);
                    hold_prev = 0;
                    gap_chk = 1;
                end else begin
                    m_ready = 1'b0;
                    wcnt--;
                    hold_prev = 1;
                    prev_data = m_wdata;
                end
            end else begin
                m_ready = 1'b0;
                wcnt = wait_cfg;
                hold_prev = 0;
                if (gap_chk) begin
                    check(force_mode ? "R10 request held after write" : "R9 request released after write",
                          {31'b0, m_req}, {31'b0, force_mode});
                    gap_chk = 0;
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic [31:0] d, input int gap);
        @(negedge clk);
        cap_valid = 1'b1; cap_data = d;
        @(negedge clk);
        cap_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(5'h0C, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 6; i++) begin
            rd(5'(i * 4), v);
            check("R1 reset value", v, 32'd0);
        end
        check("R9 no request at reset", {31'b0, m_req}, 32'd0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(5'h00, 32'h6);
        rd(5'h00, v); check("R1 control readback", v, 32'h6);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h1000_0003);
        rd(5'h04, v); check("R1 start address low bits zero", v, 32'h1000_0000);
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, v); check("R1 count is 17 bits", v, 32'h0001_FFFF);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        log_a.delete(); log_d.delete();
        force_mode = 0; wait_cfg = 1; gnt_en = 1'b1;
        wr(5'h04, 32'h200);
        wr(5'h08, 32'd3);
        wr(5'h00, 32'h1);
        rd(5'h0C, v); check("R6 active after enable", v & 32'h1, 32'h1);
        rd(5'h10, v); check("R2 live address loaded", v, 32'h200);
        rd(5'h14, v); check("R2 remaining loaded", v, 32'd3);
        wr(5'h04, 32'h900);
        wr(5'h08, 32'd9);
        for (int i = 0; i < 6; i++) send(32'hA0 + 32'(i), 0);
        wait_idle();
        rd(5'h00, v); check("R3 enable auto cleared", v & 32'h1, 32'h0);
        check("R3 number of words", 32'(log_a.size()), 32'd4);
        for (int i = 0; i < 4 && i < log_a.size(); i++) begin
            check("R4 write address", log_a[i], 32'h200 + 32'(4 * i));
            check("R4 write data", log_d[i], 32'hA0 + 32'(i));
        end
        rd(5'h14, v); check("R4 remaining holds 0", v, 32'd0);
        rd(5'h10, v); check("R4 live address past end", v, 32'h210);
        rd(5'h0C, v); check("R6 idle after drain", v & 32'h1, 32'h0);
        rd(5'h04, v); check("R11 start write ignored while active", v, 32'h200);
        rd(5'h08, v); check("R11 count write ignored while active", v, 32'd3);
        check("R9 no request when idle", {31'b0, m_req}, 32'd0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        log_a.delete(); log_d.delete();
        force_mode = 0; wait_cfg = 0; gnt_en = 1'b0;
        wr(5'h04, 32'h3000);
        wr(5'h08, 32'd15);
        wr(5'h00, 32'h1);
        for (int i = 0; i < 10; i++) send(32'(i), 0);
        check("R9 request while FIFO non-empty", {31'b0, m_req}, 32'd1);
        rd(5'h0C, v); check("R7 overflow flag set", v, 32'h3);
        gnt_en = 1'b1;
        repeat (40) @(negedge clk);
        for (int i = 10; i < 18; i++) send(32'(i), 8);
        wait_idle();
        check("R7 capture continues after drop", 32'(log_a.size()), 32'd16);
        for (int i = 0; i < 16 && i < log_a.size(); i++) begin
            check("R7 surviving data", log_d[i], (i < 8) ? 32'(i) : 32'(i + 2));
            check("R4 overflow run address", log_a[i], 32'h3000 + 32'(4 * i));
        end
        rd(5'h0C, v); check("R7 flag sticky", v, 32'h2);
        wr(5'h0C, 32'h0);
        rd(5'h0C, v); check("R7 write 0 keeps flag", v, 32'h2);
        wr(5'h0C, 32'h2);
        rd(5'h0C, v); check("R7 write 1 clears flag", v, 32'h0);
    endtask

    task automatic t_circular();
        logic [31:0] v;
        log_a.delete(); log_d.delete();
        force_mode = 1; wait_cfg = 2; gnt_en = 1'b1;
        wr(5'h04, 32'h400);
        wr(5'h08, 32'd2);
        wr(5'h00, 32'h7);
        repeat (3) @(negedge clk);
        check("R10 request held with empty FIFO", {31'b0, m_req}, 32'd1);
        for (int i = 0; i < 7; i++) send(32'hC0 + 32'(i), 10);
        rd(5'h00, v); check("R5 enable stays set", v, 32'h7);
        wr(5'h00, 32'h0);
        wait_idle();
        check("R5 word count", 32'(log_a.size()), 32'd7);
        for (int i = 0; i < 7 && i < log_a.size(); i++) begin
            check("R5 wrapped address", log_a[i], 32'h400 + 32'(4 * (i % 3)));
            check("R5 data order", log_d[i], 32'hC0 + 32'(i));
        end
        rd(5'h10, v); check("R5 live address after wrap", v, 32'h404);
        rd(5'h14, v); check("R5 remaining reloaded", v, 32'd1);
        force_mode = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_oneshot();
        t_overflow();
        t_circular();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R6 watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule